// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the scan timing for a parallel RGB panel: horizontal and vertical sync, a data-enable qualifier, and the column and row index of the pixel being shown. Each axis walks through four phases in a fixed order (sync pulse, back porch, active region, front porch). The lengths of those phases and the active size come from three programmable words that are written and read through a simple single-cycle register port.

The programmed words are copied into a working copy only when a frame begins. A frame that is already being scanned therefore never sees a half-applied timing change. A level-sensitive run request starts scanning at the top of the sync phase. When the request is removed, scanning stops only after the current frame has been completed. Three one-cycle strobes feed the surrounding logic: a frame-start pulse for the interrupt logic, an end-of-frame pulse for register commit, and an underflow pulse raised when the pixel source has no data during the active region.

Top module: `raster_timing_gen`

## Requirements
- R1: After synchronous reset, hsync, vsync, de, pix_x, pix_y, vsync_evt, frame_end, underflow and cfg_rdata are all zero, and all three timing words read back as zero.
- R2: The word at address 0 holds the active width in bits 15:0 and the active height in bits 31:16. The words at address 1 (horizontal) and address 2 (vertical) each hold the sync width in bits 7:0, the back porch in bits 19:8 and the front porch in bits 31:20. cfg_rdata shows the programmed word at cfg_addr one cycle after the address is applied, and address 3 reads zero.
- R3: Each line is the sync phase, then the back porch, then the active pixels, then the front porch, with lengths in clock cycles. Each frame is the same four phases counted in lines. hsync and vsync are active high during their sync phases.
- R4: A back porch or front porch field of zero removes that phase entirely. A sync field of zero gives a one-cycle (or one-line) sync phase.
- R5: de is high only when both axes are in their active phase. pix_x and pix_y count from 0 across the active area and are zero whenever de is low.
- R6: A timing word written while a frame is being scanned has no effect on that frame and is used from the next frame onward.
- R7: vsync_evt pulses for one cycle on the first cycle of each frame. frame_end pulses for one cycle on the last cycle of each frame.
- R8: When run_req is low at the end of a frame, scanning stops after that frame's last cycle. While stopped, hsync, vsync, de and the positions are held at zero.
- R9: When run_req is sampled high while stopped, the first frame's first cycle (sync of both axes, position 0,0) appears on the outputs two clock edges later.
- R10: underflow pulses in the cycle after any cycle in which de was high and pix_valid was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the timing words |
| cfg_addr | input | 2 | Word select: 0 size, 1 horizontal, 2 vertical |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| run_req | input | 1 | Level request to scan; low stops at frame end |
| pix_valid | input | 1 | Pixel source has data for the current de cycle |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable for the active area |
| pix_x | output | 16 | Column index inside the active area |
| pix_y | output | 16 | Row index inside the active area |
| vsync_evt | output | 1 | One-cycle pulse at the first cycle of a frame |
| frame_end | output | 1 | One-cycle pulse at the last cycle of a frame |
| underflow | output | 1 | Pulse after de was high with pix_valid low |

## Verification
The bench uses two timing sets, and the second one zeroes both porches on one axis and the horizontal sync field. A design that counted a zero porch as one cycle, or that wrapped a zero count around, would give a longer line, and every later pixel would move against the expected stream. The second set is written in the middle of a scanned frame while run_req is dropped partway through the following frame. A design that loaded timing immediately would distort the first frame, and one that stopped at once would cut off the second frame. A restart with pix_valid held low checks that every active cycle produces an underflow pulse, and that scanning resumes from the top of sync rather than from wherever the counters stood.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int NUM_WORDS = 3;
  localparam int POS_W     = 16;
  localparam int SYNC_W    = 8;
  localparam int PORCH_W   = 12;
  localparam int SYNC_LSB  = 0;
  localparam int BACK_LSB  = 8;
  localparam int FRONT_LSB = 20;

  localparam logic [ADDR_W-1:0] ADDR_SIZE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HORZ = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_VERT = 2'd2;

  typedef enum logic [1:0] {PH_SYNC, PH_BACK, PH_ACT, PH_FRONT} phase_t;

  typedef struct packed {
    logic [POS_W-1:0]   act;
    logic [SYNC_W-1:0]  sync;
    logic [PORCH_W-1:0] back;
    logic [PORCH_W-1:0] front;
  } axis_cfg_t;

  function automatic axis_cfg_t unpack_axis(input logic [WORD_W-1:0] tw,
                                            input logic [POS_W-1:0] act);
    axis_cfg_t c;
    c.act   = act;
    c.sync  = tw[SYNC_LSB  +: SYNC_W];
    c.back  = tw[BACK_LSB  +: PORCH_W];
    c.front = tw[FRONT_LSB +: PORCH_W];
    return c;
  endfunction
endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              load,
  output logic [WORD_W-1:0] rdata,
  output axis_cfg_t         h_cfg,
  output axis_cfg_t         v_cfg
);
  logic [WORD_W-1:0] prog_q   [NUM_WORDS];
  logic [WORD_W-1:0] shadow_q [NUM_WORDS];

  // programmed words and the frame-start working copy
  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) begin
          prog_q[w]   <= '0;
          shadow_q[w] <= '0;
        end else begin
          if (wr_en && (addr == ADDR_W'(w)))
            prog_q[w] <= wdata;
          if (load)
            shadow_q[w] <= prog_q[w];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (int'(addr) < NUM_WORDS) begin
      rdata <= prog_q[addr];
    end else begin
      rdata <= '0;
    end
  end

  assign h_cfg = unpack_axis(shadow_q[ADDR_HORZ], shadow_q[ADDR_SIZE][POS_W-1:0]);
  assign v_cfg = unpack_axis(shadow_q[ADDR_VERT], shadow_q[ADDR_SIZE][WORD_W-1:POS_W]);
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  axis_cfg_t        cfg,
  output phase_t           phase,
  output logic [POS_W-1:0] cnt,
  output logic             period_end
);
  logic [POS_W-1:0] cur_len;
  phase_t           nxt;
  logic             phase_last;

  always_comb begin
    case (phase)
      PH_SYNC:  cur_len = (cfg.sync == '0) ? POS_W'(1) : POS_W'(cfg.sync);
      PH_BACK:  cur_len = POS_W'(cfg.back);
      PH_ACT:   cur_len = cfg.act;
      default:  cur_len = POS_W'(cfg.front);
    endcase
  end

  // next non-empty phase; empty phases are skipped
  always_comb begin
    case (phase)
      PH_SYNC:  nxt = (cfg.back != '0) ? PH_BACK :
                      (cfg.act  != '0) ? PH_ACT  :
                      (cfg.front != '0) ? PH_FRONT : PH_SYNC;
      PH_BACK:  nxt = (cfg.act  != '0) ? PH_ACT  :
                      (cfg.front != '0) ? PH_FRONT : PH_SYNC;
      PH_ACT:   nxt = (cfg.front != '0) ? PH_FRONT : PH_SYNC;
      default:  nxt = PH_SYNC;
    endcase
  end

  assign phase_last = (cnt == cur_len - POS_W'(1));
  assign period_end = phase_last && (nxt == PH_SYNC);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (step) begin
      if (phase_last) begin
        phase <= nxt;
        cnt   <= '0;
      end else begin
        cnt <= cnt + POS_W'(1);
      end
    end
  end

  // R3: the position inside a phase never reaches that phase's length
  assert_cnt_below_len_R3: assert property (@(posedge clk) disable iff (rst)
    !clear |-> (cnt < cur_len));

  // R4: a phase with a zero length is never entered
  assert_skip_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear && phase != PH_SYNC) |-> (cur_len != '0));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              run_req,
  input  logic              pix_valid,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [POS_W-1:0]  pix_x,
  output logic [POS_W-1:0]  pix_y,
  output logic              vsync_evt,
  output logic              frame_end,
  output logic              underflow
);
  axis_cfg_t        h_cfg, v_cfg;
  phase_t           h_ph, v_ph;
  logic [POS_W-1:0] h_cnt, v_cnt;
  logic             h_end, v_end;
  logic             running;
  logic             start, frame_last, load, in_act, at_origin;

  assign start      = !running && run_req;
  assign frame_last = running && h_end && v_end;
  assign load       = start || (frame_last && run_req);
  assign in_act     = running && (h_ph == PH_ACT) && (v_ph == PH_ACT);
  assign at_origin  = running && (h_ph == PH_SYNC) && (h_cnt == '0) &&
                      (v_ph == PH_SYNC) && (v_cnt == '0);

  rtg_cfg_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .load  (load),
    .rdata (cfg_rdata),
    .h_cfg (h_cfg),
    .v_cfg (v_cfg)
  );

  rtg_axis u_horz (
    .clk        (clk),
    .rst        (rst),
    .clear      (!running),
    .step       (running),
    .cfg        (h_cfg),
    .phase      (h_ph),
    .cnt        (h_cnt),
    .period_end (h_end)
  );

  rtg_axis u_vert (
    .clk        (clk),
    .rst        (rst),
    .clear      (!running),
    .step       (running && h_end),
    .cfg        (v_cfg),
    .phase      (v_ph),
    .cnt        (v_cnt),
    .period_end (v_end)
  );

  // run control: start anywhere, stop only on a frame boundary
  always_ff @(posedge clk) begin
    if (rst)
      running <= 1'b0;
    else if (start)
      running <= 1'b1;
    else if (frame_last && !run_req)
      running <= 1'b0;
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      de        <= 1'b0;
      pix_x     <= '0;
      pix_y     <= '0;
      vsync_evt <= 1'b0;
      frame_end <= 1'b0;
      underflow <= 1'b0;
    end else begin
      hsync     <= running && (h_ph == PH_SYNC);
      vsync     <= running && (v_ph == PH_SYNC);
      de        <= in_act;
      pix_x     <= in_act ? h_cnt : '0;
      pix_y     <= in_act ? v_cnt : '0;
      vsync_evt <= at_origin;
      frame_end <= frame_last;
      underflow <= de && !pix_valid;
    end
  end

  // R5: data enable never overlaps a sync pulse
  assert_de_excl_sync_R5: assert property (@(posedge clk) disable iff (rst)
    de |-> (!hsync && !vsync));

  // R5: positions are zero outside the active area
  assert_pos_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pix_x == '0 && pix_y == '0));

  // R7: frame-start pulse sits inside both sync pulses
  assert_evt_in_sync_R7: assert property (@(posedge clk) disable iff (rst)
    vsync_evt |-> (vsync && hsync));

  // R8: once stopped, outputs go quiet
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !running |=> (!hsync && !vsync && !de));

  // R8: scanning cannot end except at the last cycle of a frame
  assert_stop_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    (running && !frame_last) |=> running);

  // R6: working timing is frozen while a frame is in progress
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (running && !frame_last) |=> ($stable(h_cfg) && $stable(v_cfg)));

  // R10: an underflow pulse has a starved active cycle before it
  assert_underflow_cause_R10: assert property (@(posedge clk) disable iff (rst)
    underflow |-> ($past(de) && !$past(pix_valid)));
endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        run_req = 1'b0;
  logic        pix_valid = 1'b1;
  logic        hsync, vsync, de, vsync_evt, frame_end, underflow;
  logic [15:0] pix_x, pix_y;

  always #2 clk = ~clk; // 250 MHz

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .run_req(run_req),
    .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .vsync_evt(vsync_evt),
    .frame_end(frame_end), .underflow(underflow)
  );

  typedef struct {
    logic [38:0] v; // {hs, vs, de, x, y, vevt, fend, uf}
    string       req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  logic  last_de = 1'b0;
  bit    cnt_en = 0;
  int    de_cnt = 0, uf_cnt = 0, ve_cnt = 0, fe_cnt = 0;
  item_t mon_it;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push_item(input logic hs, input logic vs, input logic d,
                           input logic [15:0] x, input logic [15:0] y,
                           input logic ve, input logic fe, input bit pv,
                           input string req);
    item_t it;
    it.v   = {hs, vs, d, x, y, ve, fe, last_de && !pv};
    it.req = req;
    last_de = d;
    exp_q.push_back(it);
  endtask

  task automatic push_idle(input int n, input bit pv, input string req);
    for (int i = 0; i < n; i++) push_item(0, 0, 0, 0, 0, 0, 0, pv, req);
  endtask

  task automatic push_frame(input int hs, input int hb, input int ha, input int hf,
                            input int vs, input int vb, input int va, input int vf,
                            input bit pv, input string req);
    int hse = (hs == 0) ? 1 : hs;
    int vse = (vs == 0) ? 1 : vs;
    int ht  = hse + hb + ha + hf;
    int vt  = vse + vb + va + vf;
    for (int v = 0; v < vt; v++) begin
      for (int h = 0; h < ht; h++) begin
        logic hin, vin, d;
        hin = (h >= hse + hb) && (h < hse + hb + ha);
        vin = (v >= vse + vb) && (v < vse + vb + va);
        d   = hin && vin;
        push_item(h < hse, v < vse, d,
                  d ? 16'(h - hse - hb) : 16'd0,
                  d ? 16'(v - vse - vb) : 16'd0,
                  (v == 0) && (h == 0), (v == vt - 1) && (h == ht - 1), pv, req);
      end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    @(posedge clk);
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  function automatic logic [31:0] tword(input int s, input int b, input int f);
    return {12'(f), 12'(b), 8'(s)};
  endfunction

  task automatic drain;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare one expected item per cycle
  always @(posedge clk) begin
    #1;
    if (cnt_en) begin
      de_cnt += int'(de);
      uf_cnt += int'(underflow);
      ve_cnt += int'(vsync_evt);
      fe_cnt += int'(frame_end);
    end
    if (exp_q.size() != 0) begin
      logic [38:0] act;
      string fld;
      mon_it = exp_q.pop_front();
      act = {hsync, vsync, de, pix_x, pix_y, vsync_evt, frame_end, underflow};
      checks++;
      if (act !== mon_it.v) begin
        errors++;
        if (act[36:3] !== mon_it.v[36:3]) fld = "R5";
        else if (act[2:1] !== mon_it.v[2:1]) fld = "R7";
        else if (act[0] !== mon_it.v[0]) fld = "R10";
        else fld = "R3";
        $display("FAIL %s (%s) act=%h exp=%h", mon_it.req, fld, act, mon_it.v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R1: reset state
    chk("R1 outputs", {24'd0, hsync, vsync, de, vsync_evt, frame_end, underflow, 2'b0}, 32'd0);
    chk("R1 position", {pix_y, pix_x}, 32'd0);
    chk("R1 rdata", cfg_rdata, 32'd0);
    rd_chk(2'd1, 32'd0, "R1 horizontal word");

    // R2: program timing set A and read it back
    wr(2'd0, {16'd3, 16'd4});
    wr(2'd1, tword(2, 3, 2));
    wr(2'd2, tword(1, 1, 1));
    rd_chk(2'd0, {16'd3, 16'd4}, "R2 size word");
    rd_chk(2'd1, tword(2, 3, 2), "R2 horizontal word");
    rd_chk(2'd2, tword(1, 1, 1), "R2 vertical word");
    rd_chk(2'd3, 32'd0, "R2 unused address");

    // R3/R9: start, frame A; R6/R4: set B written mid-frame; R8: stop mid B
    @(negedge clk);
    run_req = 1'b1;
    push_idle(1, 1, "R9");
    push_frame(2, 3, 4, 2, 1, 1, 3, 1, 1, "R3");
    push_frame(0, 0, 5, 1, 2, 0, 2, 0, 1, "R4/R6");
    push_idle(6, 1, "R8");
    repeat (10) @(negedge clk);
    wr(2'd0, {16'd2, 16'd5});
    wr(2'd1, tword(0, 0, 1));
    wr(2'd2, tword(2, 0, 0));
    repeat (59) @(negedge clk);
    run_req = 1'b0;
    drain();

    // R10/R9: restart with starved pixel source, single frame of set B
    @(negedge clk);
    de_cnt = 0; uf_cnt = 0; ve_cnt = 0; fe_cnt = 0;
    cnt_en = 1;
    pix_valid = 1'b0;
    run_req = 1'b1;
    push_idle(1, 0, "R9");
    push_frame(0, 0, 5, 1, 2, 0, 2, 0, 0, "R10");
    push_idle(4, 0, "R8");
    repeat (5) @(negedge clk);
    run_req = 1'b0;
    drain();
    cnt_en = 0;
    pix_valid = 1'b1;
    chk("R5 de cycles per frame", 32'(de_cnt), 32'd10);
    chk("R10 underflow pulses", 32'(uf_cnt), 32'd10);
    chk("R7 frame start pulses", 32'(ve_cnt), 32'd1);
    chk("R7 frame end pulses", 32'(fe_cnt), 32'd1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule